// File: doc/BRIEF.md
# Masked Aliased Control-Register View Unit

This block keeps a small set of physical control registers for a processor hart: one status word, one interrupt-pending word and one interrupt-enable word, each XLEN bits wide. It also keeps a 5-bit floating-point exception-flag field and a 3-bit rounding-mode field. The wide words are not reached directly. Each one is seen through three views, at machine, supervisor and user level. A view shows only the bits its mask lets through. A write through a view replaces only those bits and leaves every other stored bit as it was. The floating-point state is reached through a flags view, a rounding-mode view and a combined view.

A single synchronous register port selects a view with a 4-bit code. Reads are combinational on the current stored state. A write with the write enable high takes effect at the next rising clock edge. Two parameters set the data width (32 or 64) and the supported privilege-mode set (0: machine only, 1: machine+user, 2: machine+supervisor+user). From these two parameters every mask is derived at elaboration.

Top module: `csr_alias_view`

## Requirements
- R1: After reset every view reads 0, except the machine status view. With XLEN=64 that view reads 0xA in bits 35:32; with XLEN=32 it reads 0.
- R2: Interrupt views mask the physical register on read. The supervisor view (codes 4 and 7) uses 0x222, and uses 0 when the mode set lacks supervisor. The user view (codes 5 and 8) uses 0x111, and uses 0 when the mode set is machine only.
- R3: A write through a supervisor or user interrupt view stores (data & viewMask) | (stored & ~viewMask), so bits outside that view keep their value.
- R4: A write to the machine pending view (code 3) or machine enable view (code 6) is ANDed with the machine interrupt mask. That mask is 0x888 for machine only, 0x999 for machine+user and 0xBBB for the full set.
- R5: A write to the machine status view (code 0) is ANDed with a mask chosen by XLEN and the mode set. The mask is 0x1F888 plus the top bit, to which machine+user adds 0x20011 and the full set further adds 0x7C0122.
- R6: With XLEN=64, status bits 35:32 always hold 4'b1010, whatever is written through any view.
- R7: The supervisor status view (code 1) masks with 0xDE122 plus the top bit in the full mode set, and with 0 otherwise. The user status view (code 2) masks with 0x11 whenever user mode exists. Reads AND with the mask, and writes merge as in R3 before the R5 mask applies.
- R8: A write to the flags view (code 9) keeps only data bits 4:0. A write to the rounding view (code 10) keeps only data bits 2:0. Reads of these views are zero-extended.
- R9: A write to the combined view (code 11) sets the flags from data bits 4:0 and the rounding mode from bits 7:5. A read of this view returns {rounding, flags} zero-extended.
- R10: When the mode set has no supervisor mode, supervisor views read 0 and writes to them change no stored bit.
- R11: View codes are 0 Mstatus, 1 Sstatus, 2 Ustatus, 3 Mpend, 4 Spend, 5 Upend, 6 Men, 7 Sen, 8 Uen, 9 flags, 10 rounding, 11 combined. Codes 12 to 15 read 0, and writes to them change nothing.
- R12: A write becomes visible only after the next rising clock edge. In the cycle that carries the write, the read port still shows the old value, and without a write the stored state stays constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write the selected view at the next edge |
| viewSel | input | 4 | View code (see R11) |
| wrData | input | XLEN | Data for a write |
| rdData | output | XLEN | Masked content of the selected view |

## Verification
The checker enforces a set of invariants on every clock, whatever the stimulus:
- no stored wide register holds a bit outside its machine mask;
- the XLEN=64 status bits stay hard-wired;
- narrow-view reads never show a bit outside their mask;
- supervisor views read 0 when the mode set has no supervisor mode;
- a write through a narrow interrupt view leaves the bits outside that view unchanged;
- state is frozen when no write, or only an unmapped write, occurs.

The exact values that merges produce, the coupling of the combined floating-point view to its two fields, and the old-value-before-edge timing are shown only by the bench's reference model. The bench compares that model against two configurations on every step.

// File: rtl/csr_alias_view_pkg.sv
package csr_alias_view_pkg;

  typedef enum logic [3:0] {
    V_MSTATUS = 4'd0,
    V_SSTATUS = 4'd1,
    V_USTATUS = 4'd2,
    V_MPEND   = 4'd3,
    V_SPEND   = 4'd4,
    V_UPEND   = 4'd5,
    V_MEN     = 4'd6,
    V_SEN     = 4'd7,
    V_UEN     = 4'd8,
    V_FFLAGS  = 4'd9,
    V_FRM     = 4'd10,
    V_FCSR    = 4'd11
  } view_e;

  typedef enum logic [2:0] {
    RD_NONE, RD_STATUS, RD_PEND, RD_EN, RD_FLAGS, RD_FRM, RD_FCSR
  } rd_src_e;

  // wide register index order used by the datapath
  localparam int W_STATUS = 0;
  localparam int W_PEND   = 1;
  localparam int W_EN     = 2;
  localparam int NUM_WIDE = 3;

  localparam int FLAGS_W = 5;
  localparam int FRM_W   = 3;

  typedef struct packed {
    logic [NUM_WIDE-1:0] wideWr;
    logic                flagsWr;
    logic                frmWr;
    logic                fcsrWr;
    rd_src_e             rdSrc;
    logic [63:0]         viewMask;
  } strobe_t;

  function automatic logic hasSup(int modes);
    return modes == 2;
  endfunction

  function automatic logic hasUsr(int modes);
    return modes >= 1;
  endfunction

  function automatic logic [63:0] topBit(int xlen);
    return 64'(1) << (xlen - 1);
  endfunction

  function automatic logic [63:0] xlBits(int xlen);
    return (xlen == 64) ? 64'hA_0000_0000 : 64'h0;
  endfunction

  function automatic logic [63:0] machIntMask(int modes);
    logic [63:0] m;
    m = 64'h888;
    if (hasUsr(modes)) m |= 64'h111;
    if (hasSup(modes)) m |= 64'h222;
    return m;
  endfunction

  function automatic logic [63:0] supIntMask(int modes);
    return hasSup(modes) ? 64'h222 : 64'h0;
  endfunction

  function automatic logic [63:0] usrIntMask(int modes);
    return hasUsr(modes) ? 64'h111 : 64'h0;
  endfunction

  function automatic logic [63:0] machStatMask(int xlen, int modes);
    logic [63:0] m;
    m = 64'h1F888 | topBit(xlen);
    if (hasUsr(modes)) m |= 64'h20011;
    if (hasSup(modes)) m |= 64'h7C0122;
    return m;
  endfunction

  function automatic logic [63:0] supStatMask(int xlen, int modes);
    return hasSup(modes) ? (64'hDE122 | topBit(xlen)) : 64'h0;
  endfunction

  function automatic logic [63:0] usrStatMask(int modes);
    return hasUsr(modes) ? 64'h11 : 64'h0;
  endfunction

endpackage

// File: rtl/csr_alias_view_ctrl.sv
module csr_alias_view_ctrl
  import csr_alias_view_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int MODES = 2
) (
  input  logic       wrEn,
  input  logic [3:0] viewSel,
  output strobe_t    stb
);

  localparam logic [63:0] MI_M  = machIntMask(MODES);
  localparam logic [63:0] SI_M  = supIntMask(MODES);
  localparam logic [63:0] UI_M  = usrIntMask(MODES);
  localparam logic [63:0] MST_M = machStatMask(XLEN, MODES) | xlBits(XLEN);
  localparam logic [63:0] SST_M = supStatMask(XLEN, MODES);
  localparam logic [63:0] UST_M = usrStatMask(MODES);

  always_comb begin
    stb = '0;
    stb.rdSrc = RD_NONE;
    unique case (viewSel)
      V_MSTATUS: begin stb.rdSrc = RD_STATUS; stb.viewMask = MST_M; stb.wideWr[W_STATUS] = wrEn; end
      V_SSTATUS: begin stb.rdSrc = RD_STATUS; stb.viewMask = SST_M; stb.wideWr[W_STATUS] = wrEn; end
      V_USTATUS: begin stb.rdSrc = RD_STATUS; stb.viewMask = UST_M; stb.wideWr[W_STATUS] = wrEn; end
      V_MPEND:   begin stb.rdSrc = RD_PEND;   stb.viewMask = MI_M;  stb.wideWr[W_PEND]   = wrEn; end
      V_SPEND:   begin stb.rdSrc = RD_PEND;   stb.viewMask = SI_M;  stb.wideWr[W_PEND]   = wrEn; end
      V_UPEND:   begin stb.rdSrc = RD_PEND;   stb.viewMask = UI_M;  stb.wideWr[W_PEND]   = wrEn; end
      V_MEN:     begin stb.rdSrc = RD_EN;     stb.viewMask = MI_M;  stb.wideWr[W_EN]     = wrEn; end
      V_SEN:     begin stb.rdSrc = RD_EN;     stb.viewMask = SI_M;  stb.wideWr[W_EN]     = wrEn; end
      V_UEN:     begin stb.rdSrc = RD_EN;     stb.viewMask = UI_M;  stb.wideWr[W_EN]     = wrEn; end
      V_FFLAGS:  begin stb.rdSrc = RD_FLAGS;  stb.flagsWr = wrEn; end
      V_FRM:     begin stb.rdSrc = RD_FRM;    stb.frmWr   = wrEn; end
      V_FCSR:    begin stb.rdSrc = RD_FCSR;   stb.fcsrWr  = wrEn; end
      default:   begin stb.rdSrc = RD_NONE; end
    endcase
  end

endmodule

// File: rtl/csr_alias_view_dp.sv
module csr_alias_view_dp
  import csr_alias_view_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int MODES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         stb,
  input  logic [XLEN-1:0] wrData,
  output logic [XLEN-1:0] rdData,
  output logic [XLEN-1:0] statusQ,
  output logic [XLEN-1:0] pendQ,
  output logic [XLEN-1:0] enQ
);

  localparam logic [63:0] MI_M  = machIntMask(MODES);
  localparam logic [63:0] MST_M = machStatMask(XLEN, MODES);
  localparam logic [63:0] XL_B  = xlBits(XLEN);

  logic [XLEN-1:0] wideQ [NUM_WIDE];
  logic [XLEN-1:0] viewMask;
  logic [FLAGS_W-1:0] flagsQ;
  logic [FRM_W-1:0]   frmQ;

  assign viewMask = stb.viewMask[XLEN-1:0];

  for (genvar i = 0; i < NUM_WIDE; i++) begin : g_wide
    localparam logic [63:0] LEGAL = (i == W_STATUS) ? MST_M : MI_M;
    localparam logic [63:0] FIXED = (i == W_STATUS) ? XL_B : 64'h0;
    logic [XLEN-1:0] merged;
    logic [XLEN-1:0] nextVal;

    always_comb begin
      merged  = (wrData & viewMask) | (wideQ[i] & ~viewMask);
      nextVal = (merged & LEGAL[XLEN-1:0]) | FIXED[XLEN-1:0];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               wideQ[i] <= FIXED[XLEN-1:0];
      else if (stb.wideWr[i])  wideQ[i] <= nextVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagsQ <= '0;
      frmQ   <= '0;
    end else begin
      if (stb.flagsWr || stb.fcsrWr) flagsQ <= wrData[FLAGS_W-1:0];
      if (stb.frmWr)                 frmQ   <= wrData[FRM_W-1:0];
      else if (stb.fcsrWr)           frmQ   <= wrData[FLAGS_W+FRM_W-1:FLAGS_W];
    end
  end

  always_comb begin
    unique case (stb.rdSrc)
      RD_STATUS: rdData = wideQ[W_STATUS] & viewMask;
      RD_PEND:   rdData = wideQ[W_PEND]   & viewMask;
      RD_EN:     rdData = wideQ[W_EN]     & viewMask;
      RD_FLAGS:  rdData = XLEN'(flagsQ);
      RD_FRM:    rdData = XLEN'(frmQ);
      RD_FCSR:   rdData = XLEN'({frmQ, flagsQ});
      default:   rdData = '0;
    endcase
  end

  assign statusQ = wideQ[W_STATUS];
  assign pendQ   = wideQ[W_PEND];
  assign enQ     = wideQ[W_EN];

endmodule

// File: rtl/csr_alias_view.sv
module csr_alias_view
  import csr_alias_view_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int MODES = 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic [3:0]      viewSel,
  input  logic [XLEN-1:0] wrData,
  output logic [XLEN-1:0] rdData
);

  strobe_t         stb;
  logic [XLEN-1:0] statusQ;
  logic [XLEN-1:0] pendQ;
  logic [XLEN-1:0] enQ;

  csr_alias_view_ctrl #(.XLEN(XLEN), .MODES(MODES)) u_ctrl (
    .wrEn    (wrEn),
    .viewSel (viewSel),
    .stb     (stb)
  );

  csr_alias_view_dp #(.XLEN(XLEN), .MODES(MODES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrData  (wrData),
    .rdData  (rdData),
    .statusQ (statusQ),
    .pendQ   (pendQ),
    .enQ     (enQ)
  );

endmodule

// File: rtl/csr_alias_view_chk.sv
module csr_alias_view_chk
  import csr_alias_view_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int MODES = 2
) (
  input logic            clk,
  input logic            rstN,
  input logic            wrEn,
  input logic [3:0]      viewSel,
  input logic [XLEN-1:0] rdData,
  input logic [XLEN-1:0] statusQ,
  input logic [XLEN-1:0] pendQ,
  input logic [XLEN-1:0] enQ
);

  localparam logic [63:0] MI_M  = machIntMask(MODES);
  localparam logic [63:0] LEGAL_ST = machStatMask(XLEN, MODES) | xlBits(XLEN);
  localparam logic        IS64 = (XLEN == 64);
  localparam logic        NO_SUP = !hasSup(MODES);

  logic [63:0] st64, rd64, pd64, en64;
  assign st64 = 64'(statusQ);
  assign rd64 = 64'(rdData);
  assign pd64 = 64'(pendQ);
  assign en64 = 64'(enQ);

  assert_pend_legal_R4: assert property (@(posedge clk) disable iff (!rstN)
    (pd64 & ~MI_M) == 64'h0);
  assert_en_legal_R4: assert property (@(posedge clk) disable iff (!rstN)
    (en64 & ~MI_M) == 64'h0);
  assert_status_legal_R5: assert property (@(posedge clk) disable iff (!rstN)
    (st64 & ~LEGAL_ST) == 64'h0);
  assert_xl_fixed_R6: assert property (@(posedge clk) disable iff (!rstN)
    !IS64 || st64[35:32] == 4'b1010);
  assert_sup_int_view_R2: assert property (@(posedge clk) disable iff (!rstN)
    (viewSel == V_SPEND || viewSel == V_SEN) |-> (rd64 & ~64'h222) == 64'h0);
  assert_usr_int_view_R2: assert property (@(posedge clk) disable iff (!rstN)
    (viewSel == V_UPEND || viewSel == V_UEN) |-> (rd64 & ~64'h111) == 64'h0);
  assert_usr_stat_view_R7: assert property (@(posedge clk) disable iff (!rstN)
    (viewSel == V_USTATUS) |-> (rd64 & ~64'h11) == 64'h0);
  assert_flags_width_R8: assert property (@(posedge clk) disable iff (!rstN)
    (viewSel == V_FFLAGS) |-> (rd64 >> 5) == 64'h0);
  assert_frm_width_R8: assert property (@(posedge clk) disable iff (!rstN)
    (viewSel == V_FRM) |-> (rd64 >> 3) == 64'h0);
  assert_no_sup_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    (NO_SUP && (viewSel == V_SSTATUS || viewSel == V_SPEND || viewSel == V_SEN))
      |-> rd64 == 64'h0);
  assert_spend_merge_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && viewSel == V_SPEND) |=> (pd64 & ~64'h222) == ($past(pd64) & ~64'h222));
  assert_uen_merge_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && viewSel == V_UEN) |=> (en64 & ~64'h111) == ($past(en64) & ~64'h111));
  assert_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ($stable(statusQ) && $stable(pendQ) && $stable(enQ)));
  assert_unmapped_R11: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && viewSel >= 4'd12) |=> ($stable(statusQ) && $stable(pendQ) && $stable(enQ)));

endmodule

bind csr_alias_view csr_alias_view_chk #(.XLEN(XLEN), .MODES(MODES)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .wrEn    (wrEn),
  .viewSel (viewSel),
  .rdData  (rdData),
  .statusQ (statusQ),
  .pendQ   (pendQ),
  .enQ     (enQ)
);

// File: tb/csr_alias_view_tb.sv
module csr_alias_view_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  viewSel = 4'd0;
  logic [63:0] wrData = 64'h0;
  logic [63:0] rdA;
  logic [31:0] rdB;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csr_alias_view #(.XLEN(64), .MODES(2)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .viewSel(viewSel),
    .wrData(wrData), .rdData(rdA)
  );

  csr_alias_view #(.XLEN(32), .MODES(1)) u_dutMu (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .viewSel(viewSel),
    .wrData(wrData[31:0]), .rdData(rdB)
  );

  // reference state and masks, index 0: 64-bit full set, 1: 32-bit machine+user
  logic [63:0] mSt [2];
  logic [63:0] mPd [2];
  logic [63:0] mEn [2];
  logic [4:0]  mFl [2];
  logic [2:0]  mRm [2];
  logic [63:0] kMi [2], kSi [2], kUi [2], kMst [2], kSst [2], kUst [2], kXl [2], kWid [2];

  function automatic logic [63:0] merge(logic [63:0] d, logic [63:0] cur, logic [63:0] m);
    return (d & m) | (cur & ~m);
  endfunction

  function automatic logic [63:0] mRead(int d, int v);
    case (v)
      0: return mSt[d];
      1: return mSt[d] & kSst[d];
      2: return mSt[d] & kUst[d];
      3: return mPd[d];
      4: return mPd[d] & kSi[d];
      5: return mPd[d] & kUi[d];
      6: return mEn[d];
      7: return mEn[d] & kSi[d];
      8: return mEn[d] & kUi[d];
      9: return {59'h0, mFl[d]};
      10: return {61'h0, mRm[d]};
      11: return {56'h0, mRm[d], mFl[d]};
      default: return 64'h0;
    endcase
  endfunction

  task automatic mWrite(int d, int v, logic [63:0] xIn);
    logic [63:0] x;
    x = xIn & kWid[d];
    case (v)
      0: mSt[d] = (x & kMst[d]) | kXl[d];
      1: mSt[d] = (merge(x, mSt[d], kSst[d]) & kMst[d]) | kXl[d];
      2: mSt[d] = (merge(x, mSt[d], kUst[d]) & kMst[d]) | kXl[d];
      3: mPd[d] = x & kMi[d];
      4: mPd[d] = merge(x, mPd[d], kSi[d]) & kMi[d];
      5: mPd[d] = merge(x, mPd[d], kUi[d]) & kMi[d];
      6: mEn[d] = x & kMi[d];
      7: mEn[d] = merge(x, mEn[d], kSi[d]) & kMi[d];
      8: mEn[d] = merge(x, mEn[d], kUi[d]) & kMi[d];
      9: mFl[d] = x[4:0];
      10: mRm[d] = x[2:0];
      11: begin mFl[d] = x[4:0]; mRm[d] = x[7:5]; end
      default: ;
    endcase
  endtask

  task automatic compare(int d, int v, logic [63:0] act, string tag);
    logic [63:0] exp;
    exp = mRead(d, v);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s dut%0d view %0d actual %h expected %h", tag, d, v, act, exp);
    end
  endtask

  // one clock: drive at negedge, compare pre-edge read, then advance model
  task automatic step(int v, bit we, logic [63:0] x, string tag);
    @(negedge clk);
    viewSel = 4'(v);
    wrEn = we;
    wrData = x;
    #1;
    compare(0, v, rdA, tag);
    compare(1, v, {32'h0, rdB}, tag);
    @(posedge clk);
    if (we) begin
      mWrite(0, v, x);
      mWrite(1, v, x);
    end
  endtask

  initial begin
    kMi[0] = 64'hBBB; kSi[0] = 64'h222; kUi[0] = 64'h111;
    kMst[0] = 64'h8000_0000_007F_F9BB; kSst[0] = 64'h8000_0000_000D_E122;
    kUst[0] = 64'h11; kXl[0] = 64'hA_0000_0000; kWid[0] = '1;
    kMi[1] = 64'h999; kSi[1] = 64'h0; kUi[1] = 64'h111;
    kMst[1] = 64'h8003_F899; kSst[1] = 64'h0;
    kUst[1] = 64'h11; kXl[1] = 64'h0; kWid[1] = 64'hFFFF_FFFF;
    for (int d = 0; d < 2; d++) begin
      mSt[d] = kXl[d]; mPd[d] = '0; mEn[d] = '0; mFl[d] = '0; mRm[d] = '0;
    end

    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset values on every view
    for (int v = 0; v < 16; v++) step(v, 1'b0, 64'h0, "R1");

    // R4: machine interrupt writes masked
    step(3, 1'b1, '1, "R4");
    step(3, 1'b0, 64'h0, "R4");
    step(6, 1'b1, 64'hFFFF_0000_0000_0AAA, "R4");
    step(6, 1'b0, 64'h0, "R4");

    // R2: narrow interrupt views
    step(4, 1'b0, 64'h0, "R2");
    step(5, 1'b0, 64'h0, "R2");
    step(7, 1'b0, 64'h0, "R2");
    step(8, 1'b0, 64'h0, "R2");

    // R3: merges keep outside bits
    step(4, 1'b1, 64'h0, "R3");
    step(3, 1'b0, 64'h0, "R3");
    step(8, 1'b1, '1, "R3");
    step(6, 1'b0, 64'h0, "R3");
    step(5, 1'b1, 64'h110, "R3");
    step(3, 1'b0, 64'h0, "R3");

    // R5 / R6: machine status mask and hard-wired width fields
    step(0, 1'b1, '1, "R5");
    step(0, 1'b0, 64'h0, "R5");
    step(0, 1'b1, 64'h0, "R6");
    step(0, 1'b0, 64'h0, "R6");

    // R7: supervisor and user status views
    step(1, 1'b1, '1, "R7");
    step(0, 1'b0, 64'h0, "R7");
    step(2, 1'b1, 64'h1, "R7");
    step(0, 1'b0, 64'h0, "R7");
    step(1, 1'b0, 64'h0, "R7");
    step(2, 1'b0, 64'h0, "R7");

    // R8: floating-point field widths
    step(9, 1'b1, '1, "R8");
    step(9, 1'b0, 64'h0, "R8");
    step(10, 1'b1, '1, "R8");
    step(10, 1'b0, 64'h0, "R8");
    step(11, 1'b0, 64'h0, "R8");

    // R9: combined view
    step(11, 1'b1, 64'hA5, "R9");
    step(9, 1'b0, 64'h0, "R9");
    step(10, 1'b0, 64'h0, "R9");
    step(11, 1'b0, 64'h0, "R9");

    // R10: supervisor views on the machine+user instance
    step(0, 1'b1, 64'h0, "R10");
    step(1, 1'b1, '1, "R10");
    step(0, 1'b0, 64'h0, "R10");
    step(7, 1'b1, '1, "R10");
    step(6, 1'b0, 64'h0, "R10");
    step(4, 1'b0, 64'h0, "R10");

    // R11: unmapped codes
    step(13, 1'b1, '1, "R11");
    step(13, 1'b0, 64'h0, "R11");
    step(15, 1'b1, '1, "R11");
    step(3, 1'b0, 64'h0, "R11");
    step(0, 1'b0, 64'h0, "R11");

    // R12: old value during the write cycle, new value after
    step(6, 1'b1, 64'h0, "R12");
    step(6, 1'b1, 64'h888, "R12");
    step(6, 1'b0, 64'h0, "R12");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule